// File: doc/BRIEF.md
# Run-Time Precision SIMD Integer Multiply-Accumulate

This block multiplies two packed 64-bit operand words lane by lane and adds each signed product into a saturating accumulator for that lane. A two-bit precision input decides how the operand words are split. They can be split into sixteen 4-bit lanes, eight 8-bit lanes, two 16-bit lanes or one 32-bit lane. Narrow precisions therefore give more products for every accepted issue, and all four splits share one product register and one accumulator register.

Issues arrive on a valid/ready handshake and the unit can accept one every cycle. A clear input zeros every accumulator. A read request returns the whole packed accumulator image one cycle later, and that image includes every issue accepted before the request. The precision can be changed only when no product is in flight, and the change also clears the accumulators.

Top module: `simd_mac`

## Requirements
- R1: Precision code 0 selects 4-bit lanes: lane i takes operand bits [4i+3:4i] (i = 0..15) and its 16-bit accumulator appears at rd_data[16i+15:16i].
- R2: Precision code 1 selects 8-bit lanes: lane i takes operand bits [8i+7:8i] (i = 0..7) and its 32-bit accumulator appears at rd_data[32i+31:32i].
- R3: Precision code 2 selects two 16-bit lanes: lane i takes operand bits [32i+15:32i], the other operand bits are ignored, lane i's 64-bit accumulator appears at rd_data[64i+63:64i], and rd_data[255:128] reads zero.
- R4: Precision code 3 selects one 32-bit lane: it takes operand bits [31:0], bits [63:32] are ignored, its 128-bit accumulator appears at rd_data[127:0], and rd_data[255:128] reads zero.
- R5: Lane values are signed two's complement, and each accepted issue adds the signed product a_i*b_i to accumulator i.
- R6: Each accumulator is four times its lane width. A sum that would pass the signed limit of the accumulator is held at that limit instead of wrapping.
- R7: An issue is accepted on a rising edge where in_valid and in_ready are both high. in_ready is high whenever clr is low and the mode input equals the active precision, so back-to-back issues are accepted.
- R8: When rd_en is high in a cycle, rd_valid is high in the next cycle and rd_data then holds the accumulators with every issue accepted in earlier cycles included. An issue accepted in the same cycle as the read is not included.
- R9: When clr is high in a cycle, in_ready is low, the issue offered in that cycle is refused, any product still in flight is dropped, and all accumulators become zero.
- R10: When the mode input differs from the active precision, in_ready stays low until no product is in flight. The new precision then takes effect at the next edge and all accumulators are cleared.
- R11: After reset, rd_valid is low, the active precision is code 0 and all accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Requested precision: 0=4-bit, 1=8-bit, 2=16-bit, 3=32-bit |
| in_valid | input | 1 | Issue offered |
| in_ready | output | 1 | Issue can be accepted this cycle |
| op_a | input | 64 | Packed first operands |
| op_b | input | 64 | Packed second operands |
| clr | input | 1 | Zero all accumulators; wins over an issue in the same cycle |
| rd_en | input | 1 | Request an accumulator read |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 256 | Packed accumulator image |

## Verification
An accepted product is registered at the acceptance edge and is added into its accumulator at the following edge. A read samples the next-state accumulator value at its own edge, so a read requested in the cycle right after an issue must already show that issue. The handshake signal in_ready responds within the same cycle to clr and to the mode input. A mode change made while a product is in flight holds in_ready low for two edges instead of one. The bench drives every input on the falling edge and samples results on the next falling edge. Each check therefore lands exactly one rising edge after the stimulus it judges, and the in-flight mode change is checked at both of its edges.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

  typedef enum logic [1:0] {
    PREC_4  = 2'd0,
    PREC_8  = 2'd1,
    PREC_16 = 2'd2,
    PREC_32 = 2'd3
  } prec_e;

  localparam int NMODES = 4;
  // modes at or above this index place one lane in the low half of a double-width slice
  localparam int WIDE_FROM = 2;

  function automatic int lane_w(input int m, input int min_w);
    return min_w << m;
  endfunction

  function automatic int lane_stride(input int m, input int min_w);
    return (m >= WIDE_FROM) ? 2 * (min_w << m) : (min_w << m);
  endfunction

endpackage

// File: rtl/simd_mac_ctl.sv
module simd_mac_ctl
  import simd_mac_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  prec_e mode_in,
  input  logic  clr,
  input  logic  s1_vld,
  output prec_e mode_q,
  output logic  in_ready,
  output logic  zero_acc
);

  logic switch_now;

  // a new precision may only land once the product stage is empty
  assign switch_now = (mode_in != mode_q) && !s1_vld;
  assign in_ready   = !rst && !clr && (mode_in == mode_q);
  assign zero_acc   = clr || switch_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PREC_4;
    end else if (switch_now) begin
      mode_q <= mode_in;
    end
  end

endmodule

// File: rtl/simd_mac_mul.sv
module simd_mac_mul
  import simd_mac_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int MIN_W   = 4,
  parameter int ACC_MUL = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fire,
  input  prec_e                       mode_q,
  input  logic [DATA_W-1:0]           op_a,
  input  logic [DATA_W-1:0]           op_b,
  output logic [DATA_W*ACC_MUL-1:0]   prod_q,
  output logic                        s1_vld
);

  localparam int ACC_TOT = DATA_W * ACC_MUL;

  logic [ACC_TOT-1:0] pm [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int LW = lane_w(m, MIN_W);
    localparam int ST = lane_stride(m, MIN_W);
    localparam int NL = DATA_W / ST;
    localparam int AW = ACC_MUL * LW;
    localparam int PW = 2 * LW;

    logic [ACC_TOT-1:0] pv;

    always_comb begin
      logic signed [LW-1:0] xa;
      logic signed [LW-1:0] xb;
      logic signed [PW-1:0] p;
      pv = '0;
      for (int i = 0; i < NL; i++) begin
        xa = op_a[i*ST +: LW];
        xb = op_b[i*ST +: LW];
        p  = PW'(xa) * PW'(xb);
        // signed product widened to the lane's accumulator field
        pv[i*AW +: AW] = AW'(p);
      end
    end

    assign pm[m] = pv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= fire;
      if (fire) begin
        prod_q <= pm[mode_q];
      end
    end
  end

endmodule

// File: rtl/simd_mac_acc.sv
module simd_mac_acc
  import simd_mac_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int MIN_W   = 4,
  parameter int ACC_MUL = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      zero_acc,
  input  logic                      s1_vld,
  input  prec_e                     mode_q,
  input  logic [DATA_W*ACC_MUL-1:0] prod_q,
  output logic [DATA_W*ACC_MUL-1:0] acc_q,
  output logic [DATA_W*ACC_MUL-1:0] acc_nxt
);

  localparam int ACC_TOT = DATA_W * ACC_MUL;

  logic [ACC_TOT-1:0] am [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int LW = lane_w(m, MIN_W);
    localparam int ST = lane_stride(m, MIN_W);
    localparam int NL = DATA_W / ST;
    localparam int AW = ACC_MUL * LW;

    logic [ACC_TOT-1:0] sv;

    always_comb begin
      logic [AW:0] s;
      sv = '0;
      for (int i = 0; i < NL; i++) begin
        s = {acc_q[i*AW+AW-1], acc_q[i*AW +: AW]}
          + {prod_q[i*AW+AW-1], prod_q[i*AW +: AW]};
        if (s[AW] != s[AW-1]) begin
          // clamp to the nearest signed limit
          sv[i*AW +: AW] = s[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
        end else begin
          sv[i*AW +: AW] = s[AW-1:0];
        end
      end
    end

    assign am[m] = sv;
  end

  always_comb begin
    acc_nxt = acc_q;
    if (zero_acc) begin
      acc_nxt = '0;
    end else if (s1_vld) begin
      acc_nxt = am[mode_q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_nxt;
    end
  end

endmodule

// File: rtl/simd_mac.sv
module simd_mac
  import simd_mac_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int MIN_W   = 4,
  parameter int ACC_MUL = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                mode,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DATA_W-1:0]         op_a,
  input  logic [DATA_W-1:0]         op_b,
  input  logic                      clr,
  input  logic                      rd_en,
  output logic                      rd_valid,
  output logic [DATA_W*ACC_MUL-1:0] rd_data
);

  localparam int ACC_TOT = DATA_W * ACC_MUL;

  prec_e              mode_in;
  prec_e              mode_q;
  logic               zero_acc;
  logic               s1_vld;
  logic               fire;
  logic [ACC_TOT-1:0] prod_q;
  logic [ACC_TOT-1:0] acc_q;
  logic [ACC_TOT-1:0] acc_nxt;

  assign mode_in = prec_e'(mode);
  assign fire    = in_valid && in_ready;

  simd_mac_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .mode_in  (mode_in),
    .clr      (clr),
    .s1_vld   (s1_vld),
    .mode_q   (mode_q),
    .in_ready (in_ready),
    .zero_acc (zero_acc)
  );

  simd_mac_mul #(
    .DATA_W  (DATA_W),
    .MIN_W   (MIN_W),
    .ACC_MUL (ACC_MUL)
  ) u_mul (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .mode_q (mode_q),
    .op_a   (op_a),
    .op_b   (op_b),
    .prod_q (prod_q),
    .s1_vld (s1_vld)
  );

  simd_mac_acc #(
    .DATA_W  (DATA_W),
    .MIN_W   (MIN_W),
    .ACC_MUL (ACC_MUL)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .zero_acc (zero_acc),
    .s1_vld   (s1_vld),
    .mode_q   (mode_q),
    .prod_q   (prod_q),
    .acc_q    (acc_q),
    .acc_nxt  (acc_nxt)
  );

  // the read captures the value the accumulators take at this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= acc_nxt;
      end
    end
  end

endmodule

// File: rtl/simd_mac_chk.sv
module simd_mac_chk #(
  parameter int ACC_TOT = 256
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         mode,
  input logic [1:0]         mode_q,
  input logic               in_valid,
  input logic               in_ready,
  input logic               clr,
  input logic               rd_en,
  input logic               rd_valid,
  input logic               s1_vld,
  input logic [ACC_TOT-1:0] acc_q
);

  // R7: readiness only with a matching precision
  a_r7_ready_match: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (mode == mode_q));

  // R7: an accepted issue fills the product stage
  a_r7_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> s1_vld);

  // R9: clear empties accumulators and product stage
  a_r9_clr_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));

  a_r9_no_issue: assert property (@(posedge clk) disable iff (rst)
    clr |=> !s1_vld);

  // R10: a precision change clears and happens only when idle
  a_r10_switch_clear: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> (acc_q == '0));

  a_r10_switch_idle: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> !$past(s1_vld));

  // R8: read answers exactly one cycle later
  a_r8_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r8_rd_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R3/R4: wide modes leave the upper half of the accumulator image zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    mode_q[1] |-> (acc_q[ACC_TOT-1 -: ACC_TOT/2] == '0));

endmodule

bind simd_mac simd_mac_chk #(.ACC_TOT(ACC_TOT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .mode_q   (mode_q),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .clr      (clr),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .s1_vld   (s1_vld),
  .acc_q    (acc_q)
);

// File: tb/simd_mac_test.sv
`timescale 1ns/1ps
module simd_mac_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'd0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  op_a = '0;
  logic [63:0]  op_b = '0;
  logic         clr = 1'b0;
  logic         rd_en = 1'b0;
  logic         rd_valid;
  logic [255:0] rd_data;

  always #2.5 clk = ~clk;

  simd_mac uut (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .clr(clr), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cur_md = 0;
  bit done = 1'b0;
  logic signed [129:0] macc [16];

  // mode, op_a, op_b
  localparam int NVEC = 8;
  localparam logic [129:0] VEC [NVEC] = '{
    {2'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
    {2'd0, 64'h8888_8888_7777_7777, 64'h7777_8888_8888_7777},
    {2'd1, 64'h7F80_01FF_1234_80FF, 64'h7F80_FF01_5678_8080},
    {2'd1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0102_0304_F0E0_D0C0},
    {2'd2, 64'h5555_7FFF_AAAA_8000, 64'h1234_8000_4321_8000},
    {2'd2, 64'h0000_FFFF_0000_0001, 64'h0000_0002_FFFF_FFFF},
    {2'd3, 64'hFFFF_FFFF_8000_0000, 64'h1234_5678_8000_0000},
    {2'd3, 64'h0000_0000_7FFF_FFFF, 64'hABCD_0000_8000_0001}
  };

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void mclear();
    for (int i = 0; i < 16; i++) macc[i] = '0;
  endfunction

  function automatic void mmac(input int md, input logic [63:0] a, input logic [63:0] b);
    int lw = 4 << md;
    int st = (md >= 2) ? 2 * lw : lw;
    int nl = 64 / st;
    int aw = 4 * lw;
    logic signed [129:0] mx, mn, s;
    longint x, y;
    mx = (130'sd1 <<< (aw - 1)) - 130'sd1;
    mn = -(130'sd1 <<< (aw - 1));
    for (int i = 0; i < nl; i++) begin
      x = longint'((a >> (i * st)) & ((64'd1 << lw) - 64'd1));
      y = longint'((b >> (i * st)) & ((64'd1 << lw) - 64'd1));
      if (x >= (longint'(1) << (lw - 1))) x -= longint'(1) << lw;
      if (y >= (longint'(1) << (lw - 1))) y -= longint'(1) << lw;
      s = macc[i] + 130'(x * y);
      if (s > mx) s = mx;
      if (s < mn) s = mn;
      macc[i] = s;
    end
  endfunction

  function automatic logic [255:0] mexp(input int md);
    int lw = 4 << md;
    int st = (md >= 2) ? 2 * lw : lw;
    int nl = 64 / st;
    int aw = 4 * lw;
    logic [255:0] e = '0;
    for (int i = 0; i < nl; i++)
      for (int bt = 0; bt < aw; bt++) e[i * aw + bt] = macc[i][bt];
    return e;
  endfunction

  function automatic string mtag(input int md);
    case (md)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input int md);
    if (md != cur_md) begin
      mode = 2'(md);
      #1;
      check(in_ready == 1'b0, "R10 ready low on pending mode", 256'(in_ready), 256'd0);
      tick();
      check(in_ready == 1'b1, "R10 ready after idle switch", 256'(in_ready), 256'd1);
      mclear();
      cur_md = md;
    end
  endtask

  task automatic issue(input logic [63:0] a, input logic [63:0] b);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    #1;
    if (!in_ready) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 issue refused actual=0 expected=1");
    end
    tick();
    in_valid = 1'b0;
    mmac(cur_md, a, b);
  endtask

  task automatic do_clr();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    mclear();
  endtask

  task automatic read_chk(input string tag);
    logic [255:0] e;
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    e = mexp(cur_md);
    check(rd_valid == 1'b1, {tag, " rd_valid"}, 256'(rd_valid), 256'd1);
    check(rd_data == e, tag, rd_data, e);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mclear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11: reset state
    check(rd_valid == 1'b0, "R11 rd_valid after reset", 256'(rd_valid), 256'd0);
    check(in_ready == 1'b1, "R11 precision code 0 active", 256'(in_ready), 256'd1);
    read_chk("R11 accumulators zero");

    // table walk: R1..R4 lane layout, R5 signed products, R7 back-to-back issue
    for (int v = 0; v < NVEC; v++) begin
      set_mode(int'(VEC[v][129:128]));
      do_clr();
      issue(VEC[v][127:64], VEC[v][63:0]);
      issue(VEC[v][127:64], VEC[v][63:0]);
      read_chk({mtag(cur_md), "/R5 vector"});
    end

    // R10: precision change clears accumulators, waits for empty product stage
    set_mode(0);
    do_clr();
    issue(64'h1111_2222_3333_4444, 64'h5555_6666_7777_1111);
    mode = 2'd1;
    #1;
    check(in_ready == 1'b0, "R10 ready low while product in flight", 256'(in_ready), 256'd0);
    tick();
    check(in_ready == 1'b0, "R10 no switch with product in flight", 256'(in_ready), 256'd0);
    tick();
    check(in_ready == 1'b1, "R10 switch after drain", 256'(in_ready), 256'd1);
    cur_md = 1;
    mclear();
    read_chk("R10 accumulators cleared by switch");
    set_mode(0);

    // R9: clear beats an issue and drops an in-flight product
    do_clr();
    issue(64'h7777_7777_7777_7777, 64'h7777_7777_7777_7777);
    clr = 1'b1;
    in_valid = 1'b1;
    op_a = 64'h1234_5678_1234_5678;
    op_b = 64'h1111_1111_1111_1111;
    #1;
    check(in_ready == 1'b0, "R9 ready low during clear", 256'(in_ready), 256'd0);
    tick();
    clr = 1'b0;
    in_valid = 1'b0;
    mclear();
    read_chk("R9 clear priority and flush");

    // R8: a read excludes an issue accepted in the same cycle
    issue(64'h0000_0000_0000_0023, 64'h0000_0000_0000_0045);
    in_valid = 1'b1;
    op_a = 64'h0000_0000_0000_0011;
    op_b = 64'h0000_0000_0000_0011;
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    in_valid = 1'b0;
    check(rd_data == mexp(0), "R8 same-cycle issue excluded", rd_data, mexp(0));
    mmac(0, 64'h0000_0000_0000_0011, 64'h0000_0000_0000_0011);
    read_chk("R8 later read includes it");

    // R6: saturation at both signed limits in 4-bit lanes
    do_clr();
    for (int k = 0; k < 600; k++) issue(64'h8888_8888_8888_8888, 64'h7878_7878_7878_7878);
    read_chk("R6 saturation model");
    check(rd_data[15:0] == 16'h7FFF, "R6 positive limit", 256'(rd_data[15:0]), 256'h7FFF);
    check(rd_data[31:16] == 16'h8000, "R6 negative limit", 256'(rd_data[31:16]), 256'h8000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule